// File: doc/BRIEF.md
# Protected High-Speed Oscillator Enable Controller

This block holds the run/stop control for a high-speed oscillator behind a small register bus with address, write strobe, write data and read data. A change to the run bit is accepted only when a separate key register holds the unlock value. That unlock is used up by the next accepted access to the control register. A stop request is dropped when the CPU is clocked from this oscillator at the moment of the write. A sleep input forces the oscillator off without losing the stored run bit, so the oscillator comes back as it was programmed when sleep is released.

Each time the oscillator starts, a settling counter keeps the `clk_stable` output low for a programmable number of reference-clock cycles. The reference clock always runs. The counter restarts whenever the oscillator stops, whether software stopped it or sleep did.

Top module: `hsosc_ctrl`

## Requirements
- R1: After reset, the run bit is 1, `osc_run` is 1, `clk_stable` is 0, and the key register is locked.
- R2: When the key register holds 0x96, a write to the control register (address `CTRL_ADDR`) sets the run bit from write-data bit 1: a 1 starts the oscillator and a 0 stops it.
- R3: A write to the control register while the key register does not hold 0x96 leaves the run bit unchanged.
- R4: An unlocked write to the control register clears the key register back to locked, even when the stop request is dropped. A second control write needs a new key write.
- R5: An unlocked write of 0 to the run bit is ignored while `cpu_on_hsosc` is 1 during that write cycle. A write of 1 is still accepted.
- R6: While `sleep_req` is 1, `osc_run` and `clk_stable` are 0 and the run bit keeps its value. When `sleep_req` falls, `osc_run` returns to the run bit.
- R7: `clk_stable` rises exactly `SETTLE_CYCLES` reference-clock edges after `osc_run` becomes 1, provided `osc_run` stays 1 throughout. Any stop during that window restarts the full count.
- R8: `clk_stable` falls in the same cycle that `osc_run` falls.
- R9: Reading `CTRL_ADDR` returns the run bit on bit 1 and `clk_stable` on bit 0, with all other bits 0. Reads of the key address (`KEY_ADDR`) and of any other address return 0.
- R10: A write to `KEY_ADDR` replaces the key value. Any value other than 0x96 leaves control writes locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| cpu_on_hsosc | input | 1 | CPU currently clocked from this oscillator |
| sleep_req | input | 1 | Sleep mode active; forces the oscillator off |
| osc_run | output | 1 | Enable to the analog oscillator |
| clk_stable | output | 1 | Oscillator has settled and may be used |

## Verification
The hardest case is a settling window that is cut short. To reach it, the bench programs a start, lets the counter run partway, raises sleep for a single cycle and then releases it. It then checks that `clk_stable` needs the full `SETTLE_CYCLES` again rather than only the remainder. A second difficult case is a key that is used up by a stop request that was itself dropped because `cpu_on_hsosc` was high. The bench shows this by following that dropped request with a control write that has no new key, and confirming that the run bit does not change.

// File: rtl/hsosc_pkg.sv
package hsosc_pkg;

    // Read-data bit positions of the control register
    localparam int RUN_BIT    = 1;
    localparam int STABLE_BIT = 0;

    // Register select decoded from the bus address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_KEY  = 2'd2
    } reg_sel_e;

    // Write strobes to the register holders
    typedef struct packed {
        logic ctrl_wr;
        logic key_wr;
    } wr_strobe_t;

    // Next run bit on an unlocked control write: a 1 always starts the
    // oscillator; a 0 stops it unless the CPU is clocked from it.
    function automatic logic run_next(logic cur, logic wbit, logic cpu_src);
        return wbit | (cur & cpu_src);
    endfunction

endpackage

// File: rtl/hsosc_keylock.sv
module hsosc_keylock #(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  KEY_VAL = 8'h96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    localparam logic [DATA_W-1:0] KEY_FULL = DATA_W'(KEY_VAL);

    logic [DATA_W-1:0] key_q;

    assign unlocked = (key_q == KEY_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (key_wr) begin
            key_q <= wdata;
        end else if (ctrl_wr && unlocked) begin
            key_q <= '0;
        end
    end

    // R4: an accepted control write leaves the register locked
    assert_key_consumed_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && unlocked) |=> !unlocked);

    // R10: only a key write can unlock
    assert_unlock_needs_key_R10: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !key_wr) |=> !unlocked);

endmodule

// File: rtl/hsosc_run_reg.sv
module hsosc_run_reg
    import hsosc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic unlocked,
    input  logic wbit,
    input  logic cpu_src,
    input  logic sleep_req,
    output logic run_bit,
    output logic osc_run
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b1;
        end else if (ctrl_wr && unlocked) begin
            run_q <= run_next(run_q, wbit, cpu_src);
        end
    end

    assign run_bit = run_q;
    assign osc_run = run_q & ~sleep_req;

    // R3: locked control writes leave the run bit alone
    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !unlocked) |=> $stable(run_q));

    // R5: a stop request is dropped while the CPU runs from this oscillator
    assert_stop_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && unlocked && !wbit && cpu_src) |=> $stable(run_q));

    // R6: sleep keeps the oscillator off
    assert_sleep_forces_off_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !osc_run);

endmodule

// File: rtl/hsosc_settle_timer.sv
module hsosc_settle_timer #(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic stable
);
    localparam int                CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = run && (cnt_q == LIMIT);

    // R7: the counter never passes the settling limit
    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R8: stable only follows a cycle in which the oscillator ran
    assert_stable_after_run_R8: assert property (@(posedge clk) disable iff (rst)
        stable |-> (run && $past(run)));

endmodule

// File: rtl/hsosc_ctrl.sv
module hsosc_ctrl
    import hsosc_pkg::*;
#(
    parameter int                 ADDR_W        = 24,
    parameter int                 DATA_W        = 8,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR     = 24'h040180,
    parameter logic [ADDR_W-1:0]  KEY_ADDR      = 24'h04019E,
    parameter logic [7:0]         KEY_VAL       = 8'h96,
    parameter int                 SETTLE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_on_hsosc,
    input  logic              sleep_req,
    output logic              osc_run,
    output logic              clk_stable
);
    reg_sel_e   sel;
    wr_strobe_t wr;
    logic       unlocked;
    logic       run_bit;

    always_comb begin
        if (bus_addr == CTRL_ADDR)     sel = SEL_CTRL;
        else if (bus_addr == KEY_ADDR) sel = SEL_KEY;
        else                           sel = SEL_NONE;
    end

    assign wr.ctrl_wr = bus_wr && (sel == SEL_CTRL);
    assign wr.key_wr  = bus_wr && (sel == SEL_KEY);

    hsosc_keylock #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_keylock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr.key_wr),
        .ctrl_wr  (wr.ctrl_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    hsosc_run_reg u_run_reg (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (wr.ctrl_wr),
        .unlocked  (unlocked),
        .wbit      (bus_wdata[RUN_BIT]),
        .cpu_src   (cpu_on_hsosc),
        .sleep_req (sleep_req),
        .run_bit   (run_bit),
        .osc_run   (osc_run)
    );

    hsosc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (osc_run),
        .stable (clk_stable)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel == SEL_CTRL) begin
            bus_rdata[RUN_BIT]    = run_bit;
            bus_rdata[STABLE_BIT] = clk_stable;
        end
    end

    // R6: sleep holds the settled flag low
    assert_sleep_not_stable_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !clk_stable);

    // R9: unused read bits are zero
    assert_read_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata >> 2) == '0);

endmodule

// File: tb/test_hsosc_ctrl.sv
module test_hsosc_ctrl;
    localparam int          AW   = 24;
    localparam int          DW   = 8;
    localparam int          S    = 12;
    localparam logic [AW-1:0] CA = 24'h040180;
    localparam logic [AW-1:0] KA = 24'h04019E;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cpu_on_hsosc = 1'b0;
    logic          sleep_req = 1'b0;
    logic          osc_run;
    logic          clk_stable;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    hsosc_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CA), .KEY_ADDR(KA),
                 .KEY_VAL(8'h96), .SETTLE_CYCLES(S)) i_hsosc_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_on_hsosc(cpu_on_hsosc), .sleep_req(sleep_req),
        .osc_run(osc_run), .clk_stable(clk_stable)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic read_check(input string tag, input logic [AW-1:0] a, input int exp);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
        bus_addr = '0;
    endtask

    // Called at the negedge where osc_run has just become 1
    task automatic measure_settle(input string tag);
        int n = 0;
        for (int i = 0; i < S + 4; i++) begin
            @(negedge clk);
            n++;
            if (clk_stable) break;
        end
        check(tag, n, S);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        read_check("R1 ctrl after reset", CA, 2);
        check("R1 osc_run after reset", int'(osc_run), 1);
        measure_settle("R1/R7 settle after reset");
    endtask

    task automatic t_locked;
        bus_write(CA, 8'h00);
        read_check("R3 locked stop ignored", CA, 3);
        check("R3 osc_run stays on", int'(osc_run), 1);
        bus_write(KA, 8'h55);
        bus_write(CA, 8'h00);
        read_check("R10 wrong key stays locked", CA, 3);
    endtask

    task automatic t_unlock;
        cpu_on_hsosc = 1'b0;
        bus_write(KA, 8'h96);
        bus_write(CA, 8'h00);
        read_check("R2 unlocked stop", CA, 0);
        check("R8 osc_run and stable drop", int'({osc_run, clk_stable}), 0);
        bus_write(CA, 8'h02);
        read_check("R4 key consumed, start ignored", CA, 0);
        bus_write(KA, 8'h96);
        bus_write(CA, 8'hFD);
        read_check("R2 bit1 zero keeps stopped", CA, 0);
        bus_write(KA, 8'h96);
        @(negedge clk);
        bus_addr = CA; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
        check("R2 start sets osc_run", int'(osc_run), 1);
        measure_settle("R7 settle after start");
        read_check("R9 ctrl readback", CA, 3);
        read_check("R9 key address reads zero", KA, 0);
        read_check("R9 other address reads zero", 24'h000010, 0);
    endtask

    task automatic t_cpu_src;
        cpu_on_hsosc = 1'b1;
        bus_write(KA, 8'h96);
        bus_write(CA, 8'h00);
        read_check("R5 stop dropped when cpu source", CA, 3);
        cpu_on_hsosc = 1'b0;
        bus_write(CA, 8'h00);
        read_check("R4 key used by dropped stop", CA, 3);
        bus_write(KA, 8'h96);
        bus_write(CA, 8'h00);
        read_check("R5 stop accepted when not source", CA, 0);
        cpu_on_hsosc = 1'b1;
        bus_write(KA, 8'h96);
        bus_write(CA, 8'h02);
        check("R5 start accepted while source", int'(osc_run), 1);
        cpu_on_hsosc = 1'b0;
        measure_settle("R7 settle after start with cpu source");
    endtask

    task automatic t_sleep;
        @(negedge clk);
        sleep_req = 1'b1;
        #1;
        check("R6/R8 sleep drops run and stable", int'({osc_run, clk_stable}), 0);
        repeat (3) @(negedge clk);
        read_check("R6 run bit kept in sleep", CA, 2);
        sleep_req = 1'b0;
        #1;
        check("R6 wake restores run", int'(osc_run), 1);
        measure_settle("R6/R7 settle after wake");
        // Interrupted settle restarts the full count
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        repeat (5) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        measure_settle("R7 restart after interruption");
        // Sleep with run bit cleared stays off after wake
        bus_write(KA, 8'h96);
        bus_write(CA, 8'h00);
        sleep_req = 1'b1;
        repeat (2) @(negedge clk);
        sleep_req = 1'b0;
        #1;
        check("R6 wake keeps stopped oscillator off", int'(osc_run), 0);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_unlock();
        t_cpu_src();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule